// File: doc/BRIEF.md
# Parallel-Port FM Sample Streamer for a DDS

This block programs a direct digital synthesiser through its byte-wide parallel load port. It also produces frequency modulation by loading a fresh instantaneous frequency once per sample period, which is 50 µs at an 8 MHz clock. A sine tone is built from 20 samples per cycle. Each load is a 40-bit word sent as five bytes, each with its own write pulse, and then a single frequency-update pulse. A full burst takes 27 clocks.

The controller supplies a carrier frequency in hertz, a mode code and a one-cycle start strobe. The block then streams bursts until the next start is accepted. Each sample is the carrier plus a deviation-scaled sine value. Carriers above half the reference clock are produced on the first alias: the block programs the reference minus the requested frequency and reverses the sign of the deviation. After reset, the block holds the synthesiser's reset line high for a fixed number of cycles before any load.

Top module: `fm_dds_loader`

## Requirements
- R1: After reset, `dds_reset_o` is high for RST_CYCLES (default 4) cycles while the data bus is 0 and both strobes are low. A start strobe in that window is ignored.
- R2: A start accepted at an edge makes the next cycle burst offset 0. In offsets 1+5b to 5+5b byte b (b=0..4) is on the bus, and `dds_wr_o` is high only in the third of those five cycles. Byte 0 is always 0x00. Bytes 1 to 4 carry the 32-bit tuning word, most significant byte first.
- R3: `dds_fqud_o` is high for exactly one cycle, at burst offset 26, three cycles after the last write pulse.
- R4: Tuning word = floor((f·2^32 + REF_HZ/2) / REF_HZ), where f is the programmed frequency in Hz. With the defaults, 10 MHz gives 343597384.
- R5: Bursts repeat every SAMPLE_PERIOD (default 400) cycles. The sample index starts at 0 on each accepted start, rises by one after each update pulse, and wraps from 19 to 0.
- R6: Mode codes 2, 3 and 4 use peak deviations of 1500, 3000 and 50000 Hz. The offset for sample k is (dev·s_k) arithmetically shifted right by 14, where s_k = round(16384·sin(2πk/20)).
- R7: Mode codes 0 (CW), 1 (AM) and the unused codes 5 to 7 apply zero deviation, so every sample carries the carrier's own word.
- R8: If the carrier is above REF_HZ/2, the programmed frequency is REF_HZ − (carrier + offset). A carrier of exactly REF_HZ/2 stays on the fundamental.
- R9: A start at burst offsets 0 to 26 is ignored. A start between bursts, or in idle, latches the new carrier and mode and begins a new burst in the next cycle.
- R10: Outside burst offsets 1 to 25 the data bus is 0 and `dds_wr_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to load new carrier and mode |
| carrier_hz_i | input | 32 | Requested carrier frequency in Hz |
| mode_i | input | 3 | 0 CW, 1 AM, 2 narrow FM, 3 wide FM, 4 broadcast FM |
| dds_data_o | output | 8 | Parallel load byte |
| dds_wr_o | output | 1 | Byte write pulse |
| dds_fqud_o | output | 1 | Frequency-update pulse |
| dds_reset_o | output | 1 | Synthesiser reset |

## Verification
The assertions assume that the carrier plus the largest negative deviation stays positive and below 2^32 / 2 Hz. They also assume SAMPLE_PERIOD is long enough to hold a whole burst. The stimulus keeps every carrier between 10 MHz and 100 MHz, so the programmed frequency is always positive. It uses the default period of 400 cycles. Starts are pulsed for one cycle, both inside bursts and in the gaps between them, so both the ignore path and the accept path are exercised.

// File: rtl/fm_dds_pkg.sv
package fm_dds_pkg;

    localparam int NUM_PTS  = 20;
    localparam int SIN_FRAC = 14;

    typedef enum logic [2:0] {
        MODE_CW  = 3'd0,
        MODE_AM  = 3'd1,
        MODE_NB  = 3'd2,
        MODE_WB  = 3'd3,
        MODE_BC  = 3'd4
    } fm_mode_e;

    typedef enum logic [2:0] {
        ST_RST,
        ST_IDLE,
        ST_WAIT,
        ST_CALC,
        ST_SEND,
        ST_UPD
    } seq_state_e;

    typedef struct packed {
        logic [31:0] carrier;
        logic [2:0]  mode;
        logic [4:0]  idx;
    } sample_req_t;

    // Peak deviation in Hz for each mode code; others carry none.
    function automatic logic [16:0] mode_dev(input logic [2:0] m);
        case (m)
            MODE_NB: return 17'd1500;
            MODE_WB: return 17'd3000;
            MODE_BC: return 17'd50000;
            default: return 17'd0;
        endcase
    endfunction

    // 20-point sine in Q14, folded from one quarter wave.
    function automatic logic signed [15:0] sine_q14(input logic [4:0] k);
        logic [4:0] h;
        logic [4:0] q;
        logic signed [15:0] mag;
        h = (k >= 5'd10) ? k - 5'd10 : k;
        q = (h > 5'd5) ? 5'd10 - h : h;
        case (q)
            5'd0:    mag = 16'sd0;
            5'd1:    mag = 16'sd5063;
            5'd2:    mag = 16'sd9630;
            5'd3:    mag = 16'sd13255;
            5'd4:    mag = 16'sd15582;
            default: mag = 16'sd16384;
        endcase
        return (k >= 5'd10) ? -mag : mag;
    endfunction

endpackage

// File: rtl/fm_sample_calc.sv
module fm_sample_calc
    import fm_dds_pkg::*;
#(
    parameter int unsigned REF_HZ = 125_000_000
) (
    input  sample_req_t req_i,
    output logic [31:0] tword_o
);
    localparam int unsigned NYQ_HZ  = REF_HZ / 2;
    localparam int unsigned HALF_HZ = REF_HZ / 2;

    logic signed [31:0] dev_s;
    logic signed [15:0] sin_s;
    logic signed [47:0] prod;
    logic signed [31:0] offs;
    logic signed [35:0] fsum;
    logic signed [35:0] fprog;
    logic               alias_sel;
    logic        [63:0] num;

    always_comb begin
        dev_s     = $signed({15'd0, mode_dev(req_i.mode)});
        sin_s     = sine_q14(req_i.idx);
        prod      = 48'(dev_s) * 48'(sin_s);
        offs      = 32'(prod >>> SIN_FRAC);
        fsum      = $signed({4'd0, req_i.carrier}) + 36'(offs);
        alias_sel = req_i.carrier > NYQ_HZ;
        fprog     = alias_sel ? ($signed(36'(REF_HZ)) - fsum) : fsum;
        num       = {fprog[31:0], 32'd0} + 64'(HALF_HZ);
        tword_o   = 32'(num / 64'(REF_HZ));
    end

endmodule

// File: rtl/fm_burst_seq.sv
module fm_burst_seq
    import fm_dds_pkg::*;
#(
    parameter int unsigned SAMPLE_PERIOD = 400,
    parameter int unsigned RST_CYCLES    = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    output logic       accept_o,
    output logic       load_o,
    output logic       adv_o,
    output logic       send_o,
    output logic [2:0] byte_sel_o,
    output logic       wr_o,
    output logic       fqud_o,
    output logic       dds_rst_o
);
    localparam int TMR_W = $clog2(SAMPLE_PERIOD);
    localparam int RCW   = $clog2(RST_CYCLES + 1);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(SAMPLE_PERIOD - 1);
    localparam logic [RCW-1:0]   RC_LAST  = RCW'(RST_CYCLES - 1);

    seq_state_e       st;
    logic [TMR_W-1:0] tmr;
    logic [RCW-1:0]   rcnt;
    logic [2:0]       bidx;
    logic [2:0]       ph;

    assign accept_o   = start_i && (st == ST_IDLE || st == ST_WAIT);
    assign load_o     = (st == ST_CALC);
    assign adv_o      = (st == ST_UPD);
    assign send_o     = (st == ST_SEND);
    assign byte_sel_o = bidx;
    assign wr_o       = (st == ST_SEND) && (ph == 3'd2);
    assign fqud_o     = (st == ST_UPD);
    assign dds_rst_o  = (st == ST_RST);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_RST;
            rcnt <= '0;
            tmr  <= '0;
            bidx <= '0;
            ph   <= '0;
        end else if (accept_o) begin
            st  <= ST_CALC;
            tmr <= '0;
        end else begin
            if (st != ST_RST && st != ST_IDLE) tmr <= tmr + 1'b1;
            case (st)
                ST_RST: begin
                    if (rcnt == RC_LAST) st <= ST_IDLE;
                    else rcnt <= rcnt + 1'b1;
                end
                ST_CALC: begin
                    st   <= ST_SEND;
                    bidx <= '0;
                    ph   <= '0;
                end
                ST_SEND: begin
                    if (ph == 3'd4) begin
                        ph <= '0;
                        if (bidx == 3'd4) st <= ST_UPD;
                        else bidx <= bidx + 1'b1;
                    end else begin
                        ph <= ph + 1'b1;
                    end
                end
                ST_UPD: st <= ST_WAIT;
                ST_WAIT: begin
                    if (tmr == TMR_LAST) begin
                        st  <= ST_CALC;
                        tmr <= '0;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fm_dds_loader.sv
module fm_dds_loader
    import fm_dds_pkg::*;
#(
    parameter int unsigned REF_HZ        = 125_000_000,
    parameter int unsigned SAMPLE_PERIOD = 400,
    parameter int unsigned RST_CYCLES    = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic [31:0] carrier_hz_i,
    input  logic [2:0]  mode_i,
    output logic [7:0]  dds_data_o,
    output logic        dds_wr_o,
    output logic        dds_fqud_o,
    output logic        dds_reset_o
);
    localparam int BURST_LEN = 27;

    initial begin
        if (SAMPLE_PERIOD <= BURST_LEN)
            $error("SAMPLE_PERIOD must exceed the burst length");
    end

    sample_req_t req_q;
    logic [31:0] tword_c;
    logic [31:0] tword_q;
    logic        accept, load, adv, send;
    logic [2:0]  bsel;

    fm_burst_seq #(
        .SAMPLE_PERIOD (SAMPLE_PERIOD),
        .RST_CYCLES    (RST_CYCLES)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .accept_o   (accept),
        .load_o     (load),
        .adv_o      (adv),
        .send_o     (send),
        .byte_sel_o (bsel),
        .wr_o       (dds_wr_o),
        .fqud_o     (dds_fqud_o),
        .dds_rst_o  (dds_reset_o)
    );

    fm_sample_calc #(
        .REF_HZ (REF_HZ)
    ) u_calc (
        .req_i   (req_q),
        .tword_o (tword_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q   <= '0;
            tword_q <= '0;
        end else begin
            if (accept) begin
                req_q.carrier <= carrier_hz_i;
                req_q.mode    <= mode_i;
                req_q.idx     <= '0;
            end else if (adv) begin
                req_q.idx <= (req_q.idx == 5'(NUM_PTS - 1)) ? '0 : req_q.idx + 1'b1;
            end
            if (load) tword_q <= tword_c;
        end
    end

    always_comb begin
        dds_data_o = 8'd0;
        if (send) begin
            case (bsel)
                3'd1:    dds_data_o = tword_q[31:24];
                3'd2:    dds_data_o = tword_q[23:16];
                3'd3:    dds_data_o = tword_q[15:8];
                3'd4:    dds_data_o = tword_q[7:0];
                default: dds_data_o = 8'd0;
            endcase
        end
    end

endmodule

// File: rtl/fm_dds_loader_chk.sv
module fm_dds_loader_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] dds_data_o,
    input logic       dds_wr_o,
    input logic       dds_fqud_o,
    input logic       dds_reset_o
);
    // R2
    wr_single_chk: assert property (@(posedge clk) disable iff (rst)
        dds_wr_o |=> !dds_wr_o);

    // R2
    setup_stable_chk: assert property (@(posedge clk) disable iff (rst)
        dds_wr_o |-> $stable(dds_data_o));

    // R2
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        dds_wr_o |=> $stable(dds_data_o));

    // R3
    fqud_single_chk: assert property (@(posedge clk) disable iff (rst)
        dds_fqud_o |=> !dds_fqud_o);

    // R3
    fqud_after_wr_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dds_fqud_o) |-> $past(dds_wr_o, 3));

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        dds_reset_o |-> (!dds_wr_o && !dds_fqud_o && dds_data_o == 8'd0));

endmodule

bind fm_dds_loader fm_dds_loader_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .dds_data_o  (dds_data_o),
    .dds_wr_o    (dds_wr_o),
    .dds_fqud_o  (dds_fqud_o),
    .dds_reset_o (dds_reset_o)
);

// File: tb/fm_dds_loader_tb.sv
module fm_dds_loader_tb;
    localparam int  CLK_PERIOD = 10;
    localparam longint REF     = 125_000_000;
    localparam int  P          = 400;
    localparam int  RSTC       = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] carrier_hz_i = '0;
    logic [2:0]  mode_i = '0;
    logic [7:0]  dds_data_o;
    logic        dds_wr_o, dds_fqud_o, dds_reset_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fm_dds_loader #(.REF_HZ(125_000_000), .SAMPLE_PERIOD(P), .RST_CYCLES(RSTC)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .carrier_hz_i(carrier_hz_i),
        .mode_i(mode_i), .dds_data_o(dds_data_o), .dds_wr_o(dds_wr_o),
        .dds_fqud_o(dds_fqud_o), .dds_reset_o(dds_reset_o));

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic longint sinq(input int k);
        real v;
        v = $sin(2.0 * 3.14159265358979 * k / 20.0) * 16384.0;
        return (v >= 0.0) ? longint'($rtoi(v + 0.5)) : -longint'($rtoi(-v + 0.5));
    endfunction

    function automatic longint exp_word(input longint car, input int mode, input int k);
        longint dev, off, f;
        dev = (mode == 2) ? 1500 : (mode == 3) ? 3000 : (mode == 4) ? 50000 : 0;
        off = (dev * sinq(k)) >>> 14;
        f = (car > REF / 2) ? REF - (car + off) : car + off;
        return ((f <<< 32) + REF / 2) / REF;
    endfunction

    // Behavioural reference: phase 0 reset, 1 idle, 2 streaming
    int     mst = 0, rcnt = 0, off = 0, midx = 0, mmode = 0;
    longint mcar = 0;
    longint cyc = 0;

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            mst = 0; rcnt = 0;
        end else if (mst == 0) begin
            if (rcnt == RSTC - 1) mst = 1; else rcnt++;
        end else if (start_i && (mst == 1 || off >= 27)) begin
            mst = 2; off = 0; midx = 0; mcar = carrier_hz_i; mmode = mode_i;
        end else if (mst == 2) begin
            if (off == 26) midx = (midx + 1) % 20;
            off = (off == P - 1) ? 0 : off + 1;
        end
    end

    // Per-cycle comparison
    always @(negedge clk) begin
        if (!rst && !done) begin
            longint ed; int ew, ef, er; string tg;
            ed = 0; ew = 0; ef = 0; er = 0; tg = "R10";
            if (mst == 0) begin
                er = 1; tg = "R1";
            end else if (mst == 2 && off >= 1 && off <= 25) begin
                int b; longint w;
                b = (off - 1) / 5;
                w = exp_word(mcar, mmode, midx);
                ew = ((off - 1) % 5 == 2);
                ed = (b == 0) ? 0 : (w >> (8 * (4 - b))) & 255;
                if (b == 0) tg = "R2";
                else if (mcar > REF / 2) tg = "R8";
                else if (mmode >= 2 && mmode <= 4) tg = (midx == 0) ? "R6" : "R5";
                else if (mmode == 0) tg = "R4";
                else tg = "R7";
            end else if (mst == 2 && off == 26) begin
                ef = 1;
            end
            chk("R1 reset line", dds_reset_o, er);
            chk("R2 write pulse", dds_wr_o, ew);
            chk("R3 update pulse", dds_fqud_o, ef);
            chk({tg, " data bus"}, dds_data_o, ed);
        end
    end

    // Independent capture of the bytes between update pulses
    logic [39:0] cap = '0;
    logic [31:0] last_word = '0;
    logic [7:0]  last_b0 = '0;
    int          fq_count = 0;
    longint      fq_last_t = 0, fq_prev_t = 0;
    always @(negedge clk) begin
        if (dds_wr_o) cap = {cap[31:0], dds_data_o};
        if (dds_fqud_o) begin
            last_word = cap[31:0]; last_b0 = cap[39:32];
            fq_prev_t = fq_last_t; fq_last_t = cyc; fq_count++;
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start(input longint car, input int mode);
        @(negedge clk);
        start_i = 1'b1; carrier_hz_i = 32'(car); mode_i = 3'(mode);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_fq(input int n);
        int target;
        target = fq_count + n;
        while (fq_count < target) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        cycles(3);
        rst = 1'b0;
        // R1: start during the reset window is ignored
        start_i = 1'b1; carrier_hz_i = 32'd10_000_000; mode_i = 3'd0;
        cycles(2);
        start_i = 1'b0;
        cycles(10);
        chk("R1 no burst from start in reset window", fq_count, 0);

        // R4: CW 10 MHz word and zero control byte
        pulse_start(10_000_000, 0);
        wait_fq(1);
        chk("R4 tuning word 10MHz", last_word, 343597384);
        chk("R2 control byte zero", last_b0, 0);
        wait_fq(1);
        chk("R5 burst spacing", fq_last_t - fq_prev_t, P);

        // R6: narrowband FM at 30 MHz, sample 5, then wrap
        pulse_start(30_000_000, 2);
        wait_fq(6);
        chk("R6 narrow FM peak sample", last_word, 1030843691);
        wait_fq(16);
        chk("R5 index wraps to 1", last_word, exp_word(30_000_000, 2, 1));

        // R9: start in the middle of a burst is ignored
        pulse_start(14_000_000, 3);
        cycles(8);
        pulse_start(20_000_000, 0);
        wait_fq(1);
        chk("R9 mid-burst start ignored", last_word, exp_word(14_000_000, 3, 0));
        wait_fq(1);
        chk("R9 old params kept", last_word, exp_word(14_000_000, 3, 1));

        // R8: broadcast FM on the alias band
        pulse_start(100_000_000, 4);
        wait_fq(1);
        chk("R8 alias sample 0", last_word, 858993459);
        wait_fq(5);
        chk("R8 alias deviation reversed", last_word, exp_word(100_000_000, 4, 5));
        wait_fq(15);

        // R8 boundary and R7 no-deviation modes
        pulse_start(62_500_000, 1);
        wait_fq(1);
        chk("R8 exact half stays fundamental", last_word, 32'h8000_0000);
        pulse_start(20_000_000, 6);
        wait_fq(6);
        chk("R7 unused code has no deviation", last_word, 687194767);

        // R9: start in the gap between bursts restarts at sample 0
        cycles(50);
        pulse_start(20_000_000, 3);
        wait_fq(1);
        chk("R9 restart between bursts", last_word, exp_word(20_000_000, 3, 0));
        cycles(20);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule